// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-lane SIMD thread are allowed to commit results while the thread runs through nested if/else regions. Every lane executes every instruction. The mask that this block produces decides which lanes write back. At each branch the sequencer supplies a per-lane predicate bit, which a compare sets, together with one of three commands:

- **Enter-branch** saves the current mask and narrows it to the lanes whose predicate is set.
- **Flip** moves to the else path.
- **Leave-branch** restores the mask that was saved at the matching entry.

The block stores the predicate used at each entry next to the saved mask. Because of this, the else path is always the saved mask with the taken lanes removed. It is never a plain inversion of the current mask, so lanes that were already inactive before the branch never wake up.

The active mask is presented on registered outputs. An all-idle flag lets the sequencer skip a path on which no lane is active. Nesting is limited by a hardware stack of 8 frames. A command the stack cannot honour raises a one-cycle overflow or underflow pulse and changes nothing.

Top module: `simt_mask_stack`

## Requirements
- R1: After synchronous reset, `active_mask` is all ones, the stack holds no frames, and `lanes_idle`, `overflow` and `underflow` are 0.
- R2: Command code 2'b01 (enter-branch) with fewer than 8 frames held pushes a frame holding the current mask and `pred`. The new mask is the old mask AND `pred`.
- R3: Command code 2'b10 (flip) with at least one frame held sets the mask to the top frame's saved mask AND NOT its saved predicate. Repeating the flip gives the same mask, and the stack is unchanged.
- R4: Command code 2'b11 (leave-branch) with at least one frame held removes the top frame and restores its saved mask. Frames are restored in last-in, first-out order.
- R5: `lanes_idle` is 1 exactly when `active_mask` is all zeros, and it updates in the same cycle as the mask.
- R6: Enter-branch while 8 frames are held raises `overflow` for one cycle and leaves the mask and the stack unchanged.
- R7: Leave-branch or flip while no frame is held raises `underflow` for one cycle and leaves the mask unchanged.
- R8: Command code 2'b00 leaves the mask and the stack unchanged and raises no flag.
- R9: `pred` has no effect except under enter-branch. Under flip, leave-branch and code 2'b00 the resulting mask does not depend on it.
- R10: Eight nested enter-branch commands are all accepted, and the eight matching leave-branch commands return the mask to its value before the first entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | 00 none, 01 enter-branch, 10 flip, 11 leave-branch |
| pred | input | 32 | Per-lane branch predicate, 1 = branch taken |
| active_mask | output | 32 | Registered mask of lanes that commit |
| lanes_idle | output | 1 | Registered, 1 when no lane is active |
| overflow | output | 1 | One-cycle pulse: enter-branch refused, stack full |
| underflow | output | 1 | One-cycle pulse: flip or leave-branch refused, stack empty |

## Verification
Every result of this block is registered. A command presented before a rising edge appears on `active_mask` and `lanes_idle` in the cycle after that edge, and its overflow or underflow pulse appears in that same cycle and lasts for that cycle only. The bench drives each command at a falling edge. It advances a behavioural frame queue at the next rising edge and compares all four outputs at the falling edge that follows, so each comparison sees exactly the cycle in which that command's result is due. The directed sequences cover:

- nested entries,
- repeated flips,
- a full stack,
- an empty stack.

A long random phase then checks the same single-cycle timing on every clock.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

  localparam int unsigned LANE_COUNT  = 32;
  localparam int unsigned FRAME_COUNT = 8;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_ENTER = 2'b01,
    CMD_FLIP  = 2'b10,
    CMD_LEAVE = 2'b11
  } mask_cmd_e;

endpackage

// File: rtl/mask_frame_store.sv
// Frame memory: one saved mask and one saved predicate per nesting level.
// Written without reset so that it maps to distributed RAM.
module mask_frame_store #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned FW    = 2 * LANES
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_mask,
  input  logic [LANES-1:0] wr_pred,
  input  logic [AW-1:0]    rd_addr,
  output logic [LANES-1:0] rd_mask,
  output logic [LANES-1:0] rd_pred
);

  logic [FW-1:0] frames [DEPTH];
  logic [FW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      frames[wr_addr] <= {wr_mask, wr_pred};
    end
  end

  assign rd_word = frames[rd_addr];
  assign rd_mask = rd_word[FW-1:LANES];
  assign rd_pred = rd_word[LANES-1:0];

endmodule

// File: rtl/mask_depth_ctrl.sv
// Nesting level counter: decides which commands may proceed and which
// raise overflow or underflow.
module mask_depth_ctrl
  import simt_mask_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  mask_cmd_e cmd,
  output logic      enter_ok,
  output logic      flip_ok,
  output logic      leave_ok,
  output logic      ovf_nxt,
  output logic      udf_nxt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] top_ptr
);

  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  logic [LW-1:0] level;
  logic          is_full;
  logic          is_empty;

  assign is_full  = (level == LVL_FULL);
  assign is_empty = (level == '0);

  always_comb begin
    enter_ok = 1'b0;
    flip_ok  = 1'b0;
    leave_ok = 1'b0;
    ovf_nxt  = 1'b0;
    udf_nxt  = 1'b0;
    unique case (cmd)
      CMD_ENTER: begin
        enter_ok = !is_full;
        ovf_nxt  = is_full;
      end
      CMD_FLIP: begin
        flip_ok = !is_empty;
        udf_nxt = is_empty;
      end
      CMD_LEAVE: begin
        leave_ok = !is_empty;
        udf_nxt  = is_empty;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (enter_ok) begin
      level <= level + 1'b1;
    end else if (leave_ok) begin
      level <= level - 1'b1;
    end
  end

  assign wr_ptr  = level[AW-1:0];
  assign top_ptr = wr_ptr - 1'b1;

  // The level never leaves 0..DEPTH (R6, R7).
  assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_FULL);

  // A refused enter leaves the level unchanged (R6).
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ENTER && is_full) |=> (level == LVL_FULL));

  // A refused leave leaves the stack empty (R7).
  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LEAVE && is_empty) |=> (level == '0));

  // A flip never moves the level (R3).
  assert_flip_level_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_FLIP) |=> $stable(level));

endmodule

// File: rtl/mask_next_calc.sv
// Per-lane next-mask selection for each accepted command.
module mask_next_calc #(
  parameter int unsigned LANES = 32
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] top_mask,
  input  logic [LANES-1:0] top_pred,
  input  logic             enter_ok,
  input  logic             flip_ok,
  input  logic             leave_ok,
  output logic [LANES-1:0] nxt_mask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (enter_ok) begin
        nxt_mask[g] = cur_mask[g] & pred[g];
      end else if (flip_ok) begin
        nxt_mask[g] = top_mask[g] & ~top_pred[g];
      end else if (leave_ok) begin
        nxt_mask[g] = top_mask[g];
      end else begin
        nxt_mask[g] = cur_mask[g];
      end
    end
  end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int unsigned LANES = LANE_COUNT,
  parameter int unsigned DEPTH = FRAME_COUNT,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic             lanes_idle,
  output logic             overflow,
  output logic             underflow
);

  mask_cmd_e        cmd_e;
  logic             enter_ok;
  logic             flip_ok;
  logic             leave_ok;
  logic             ovf_nxt;
  logic             udf_nxt;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    top_ptr;
  logic [LANES-1:0] top_mask;
  logic [LANES-1:0] top_pred;
  logic [LANES-1:0] nxt_mask;
  logic [LANES-1:0] mask_q;
  logic             idle_q;
  logic             ovf_q;
  logic             udf_q;

  assign cmd_e = mask_cmd_e'(cmd);

  mask_depth_ctrl #(.DEPTH(DEPTH)) u_depth (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd_e),
    .enter_ok (enter_ok),
    .flip_ok  (flip_ok),
    .leave_ok (leave_ok),
    .ovf_nxt  (ovf_nxt),
    .udf_nxt  (udf_nxt),
    .wr_ptr   (wr_ptr),
    .top_ptr  (top_ptr)
  );

  mask_frame_store #(.LANES(LANES), .DEPTH(DEPTH)) u_frames (
    .clk     (clk),
    .wr_en   (enter_ok),
    .wr_addr (wr_ptr),
    .wr_mask (mask_q),
    .wr_pred (pred),
    .rd_addr (top_ptr),
    .rd_mask (top_mask),
    .rd_pred (top_pred)
  );

  mask_next_calc #(.LANES(LANES)) u_next (
    .cur_mask (mask_q),
    .pred     (pred),
    .top_mask (top_mask),
    .top_pred (top_pred),
    .enter_ok (enter_ok),
    .flip_ok  (flip_ok),
    .leave_ok (leave_ok),
    .nxt_mask (nxt_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      idle_q <= 1'b0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      mask_q <= nxt_mask;
      idle_q <= ~|nxt_mask;
      ovf_q  <= ovf_nxt;
      udf_q  <= udf_nxt;
    end
  end

  assign active_mask = mask_q;
  assign lanes_idle  = idle_q;
  assign overflow    = ovf_q;
  assign underflow   = udf_q;

  // Idle flag tracks the registered mask (R5).
  assert_idle_flag_R5: assert property (@(posedge clk) disable iff (rst)
    lanes_idle == (active_mask == '0));

  // Entering a branch can only drop lanes (R2).
  assert_enter_narrows_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_e == CMD_ENTER) |=> ((active_mask & ~$past(active_mask)) == '0));

  // No-op command holds the mask and raises no flag (R8).
  assert_none_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_e == CMD_NONE) |=> ($stable(active_mask) && !overflow && !underflow));

  // Overflow leaves the mask untouched (R6).
  assert_no_overflow_change_R6: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $stable(active_mask));

  // Underflow leaves the mask untouched (R7).
  assert_no_underflow_change_R7: assert property (@(posedge clk) disable iff (rst)
    underflow |-> $stable(active_mask));

  // Both error pulses never coincide (R6, R7).
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(overflow && underflow));

endmodule

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 32;
  localparam int DEPTH      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cmd = 2'b00;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] active_mask;
  logic             lanes_idle;
  logic             overflow;
  logic             underflow;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Reference state
  logic [LANES-1:0]   m_mask;
  logic [2*LANES-1:0] m_q [$];
  logic               m_ovf;
  logic               m_udf;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_mask_stack uut (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .pred        (pred),
    .active_mask (active_mask),
    .lanes_idle  (lanes_idle),
    .overflow    (overflow),
    .underflow   (underflow)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "active_mask", active_mask, m_mask);
    chk(req, "lanes_idle", {31'd0, lanes_idle}, {31'd0, (m_mask == '0)});
    chk(req, "overflow", {31'd0, overflow}, {31'd0, m_ovf});
    chk(req, "underflow", {31'd0, underflow}, {31'd0, m_udf});
  endtask

  // Drive at a falling edge, update model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input logic [1:0] c, input logic [LANES-1:0] p, input string req);
    logic [2*LANES-1:0] top;
    cmd  = c;
    pred = p;
    m_ovf = 1'b0;
    m_udf = 1'b0;
    case (c)
      2'b01: begin
        if (m_q.size() == DEPTH) m_ovf = 1'b1;
        else begin
          m_q.push_back({m_mask, p});
          m_mask = m_mask & p;
        end
      end
      2'b10: begin
        if (m_q.size() == 0) m_udf = 1'b1;
        else begin
          top = m_q[$];
          m_mask = top[2*LANES-1:LANES] & ~top[LANES-1:0];
        end
      end
      2'b11: begin
        if (m_q.size() == 0) m_udf = 1'b1;
        else begin
          top = m_q.pop_back();
          m_mask = top[2*LANES-1:LANES];
        end
      end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_mask = '1;
    m_ovf  = 1'b0;
    m_udf  = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // No-op with a busy predicate (R8, R9)
    step(2'b00, 32'h0F0F_0F0F, "R8");
    step(2'b00, 32'h0000_0000, "R9");

    // Nested branch with flips (R2, R3, R4)
    step(2'b01, 32'hFFFF_0000, "R2");
    step(2'b01, 32'hF0F0_F0F0, "R2");
    step(2'b10, 32'h1234_5678, "R3");
    step(2'b10, 32'h0000_0000, "R3");
    step(2'b11, 32'hDEAD_BEEF, "R4");
    step(2'b10, 32'hAAAA_AAAA, "R9");
    step(2'b11, 32'h0000_0000, "R4");

    // All lanes leave (R5)
    step(2'b01, 32'h0000_0000, "R5");
    step(2'b10, 32'h0000_0000, "R5");
    step(2'b11, 32'h0000_0000, "R5");

    // Fill and overflow (R10, R6)
    for (int i = 0; i < DEPTH; i++) step(2'b01, ~(32'h1 << i), "R10");
    step(2'b01, 32'h0000_FFFF, "R6");
    step(2'b00, 32'h0, "R6");
    step(2'b10, 32'h0, "R3");
    for (int i = 0; i < DEPTH; i++) step(2'b11, 32'h0, "R10");
    chk("R10", "mask restored", active_mask, 32'hFFFF_FFFF);

    // Empty stack (R7)
    step(2'b11, 32'h0, "R7");
    step(2'b10, 32'hFFFF_FFFF, "R7");
    step(2'b00, 32'h0, "R7");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  c;
      logic [31:0] p;
      c = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0:       p = $urandom() & $urandom();
        1:       p = '1;
        2:       p = 32'h1 << $urandom_range(0, 31);
        default: p = $urandom();
      endcase
      step(c, p, tag_of(c));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule